// File: doc/BRIEF.md
# Fly-by Capable DMA Transfer Sequencer

This block sequences the bus cycles of one DMA channel that moves data between an external I/O device and external memory. A start pulse loads a memory address, a byte count, a mode bit and a direction bit. After that, each granted request produces bus activity until the count is used up. The device side is never addressed. It is selected only by the channel acknowledge strobe.

The block has two modes. In dual-address mode every unit takes two ordinary one-cycle bus accesses, a read and then a write, and the acknowledge marks whichever of the two is the device access. Read data is kept in an internal holding register between the two accesses and is driven back out during the write. In fly-by mode a single memory access carries the acknowledge, so the device sources or sinks the data on that same cycle. When memory is written in fly-by mode, the block keeps its data drivers off because the device owns the bus. Both sides are assumed to share one data width.

Top module: `flyby_dma_seq`

## Requirements
- R1: While reset is held and right after it is released, mem_rd_o, mem_wr_o, ack_o, data_oe_o and done_o are all low.
- R2: A start_i pulse captures address, count, mode and direction only when no transfer is pending. A start_i pulse during a pending transfer changes nothing. A count of 0 starts nothing.
- R3: Fly-by with dir_i=1 (memory to device): each unit is one cycle with mem_rd_o and ack_o both high, mem_wr_o low and data_oe_o low.
- R4: Fly-by with dir_i=0 (device to memory): each unit is one cycle with mem_wr_o and ack_o both high, and data_oe_o stays low.
- R5: mem_addr_o equals the loaded address on the first unit and grows by DW/8 after each completed unit. The count drops by DW/8 per unit and activity ends when it reaches zero.
- R6: Dual-address with dir_i=1: a memory read cycle (mem_rd_o high, ack_o low) is followed by a write cycle with mem_wr_o, ack_o and data_oe_o high, and wr_data_o holds the value that was on rd_data_i during the read.
- R7: Dual-address with dir_i=0: a device read cycle (mem_rd_o and ack_o high) is followed by a memory write cycle with mem_wr_o and data_oe_o high, ack_o low, and wr_data_o holding the captured value.
- R8: ack_o and all strobes are high only while req_i and enable_i are both high. With either one low, a fly-by or read phase falls back to idle without using up the unit. A pending dual-address write waits and keeps its data.
- R9: done_o is high exactly in the cycle of the last unit's final access, together with that access's strobe.
- R10: mem_rd_o and mem_wr_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Channel enable |
| start_i | input | 1 | Load pulse for address, count, mode and direction |
| single_i | input | 1 | 1 = fly-by, 0 = dual-address |
| dir_i | input | 1 | 1 = memory to device, 0 = device to memory |
| src_addr_i | input | AW | Memory start address |
| byte_cnt_i | input | CW | Transfer length in bytes |
| req_i | input | 1 | Device request |
| rd_data_i | input | DW | Data bus, input side |
| mem_addr_o | output | AW | Current memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| ack_o | output | 1 | Channel acknowledge |
| data_oe_o | output | 1 | Data bus drive enable |
| wr_data_o | output | DW | Data driven when data_oe_o is high |
| done_o | output | 1 | Last-access marker |

## Verification
On every cycle the assertions check the gating of the acknowledge by request and enable, the mutual exclusion of the strobes, and that the drivers are enabled only for writes and never in fly-by mode. They also check that done_o coincides with an access, that the address steps by the bus width, and that the hold register changes only on a capture. Only the bench scenarios can show that a given mode and direction yield the correct strobe pattern, that the written word matches what was read, that a stalled write resumes with its data intact, and that a start pulse during a pending transfer or a zero count leaves the channel alone.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FLY  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/flyby_dma_ctr.sv
module flyby_dma_ctr #(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          last_o
);
  localparam logic [AW-1:0] ADDR_INC = AW'(STEP);
  localparam logic [CW-1:0] CNT_DEC  = CW'(STEP);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      cnt_q  <= cnt_i;
    end else if (step_i) begin
      addr_q <= addr_q + ADDR_INC;
      cnt_q  <= last_o ? '0 : cnt_q - CNT_DEC;
    end
  end

  assign addr_o = addr_q;
  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q <= CNT_DEC);

  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_o == $past(addr_o) + ADDR_INC));

  // R5
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(step_i));
endmodule

// File: rtl/flyby_dma_hold.sv
module flyby_dma_hold #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end

  // R8
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o));
endmodule

// File: rtl/flyby_dma_fsm.sv
module flyby_dma_fsm
  import flyby_dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic single_i,
  input  logic dir_i,
  input  logic busy_i,
  input  logic last_i,
  input  logic go_i,
  output logic mem_rd_o,
  output logic mem_wr_o,
  output logic ack_o,
  output logic oe_o,
  output logic cap_o,
  output logic step_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic single_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      single_q <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_i) begin
        single_q <= single_i;
        dir_q    <= dir_i;
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    ack_o    = 1'b0;
    oe_o     = 1'b0;
    cap_o    = 1'b0;
    step_o   = 1'b0;
    done_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (busy_i && go_i) state_d = single_q ? ST_FLY : ST_RD;
      ST_FLY: begin
        ack_o    = go_i;
        mem_rd_o = go_i & dir_q;
        mem_wr_o = go_i & ~dir_q;   // device drives the bus
        step_o   = go_i;
        done_o   = go_i & last_i;
        if (!go_i || last_i) state_d = ST_IDLE;
      end
      ST_RD: begin
        mem_rd_o = go_i;
        ack_o    = go_i & ~dir_q;   // device read phase
        cap_o    = go_i;
        state_d  = go_i ? ST_WR : ST_IDLE;
      end
      ST_WR: begin
        mem_wr_o = go_i;
        ack_o    = go_i & dir_q;    // device write phase
        oe_o     = go_i;
        step_o   = go_i;
        done_o   = go_i & last_i;
        if (go_i) state_d = last_i ? ST_IDLE : ST_RD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o}));

  // R4
  fly_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FLY) |-> !oe_o);

  // R6
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR) |-> ($past(state_q) == ST_RD || $past(state_q) == ST_WR));
endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          start_i,
  input  logic          single_i,
  input  logic          dir_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic          req_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          ack_o,
  output logic          data_oe_o,
  output logic [DW-1:0] wr_data_o,
  output logic          done_o
);
  localparam int STEP = DW / 8;

  logic go, load, busy, last, cap, step;

  assign go   = req_i & enable_i;
  assign load = start_i & ~busy;

  flyby_dma_ctr #(.AW(AW), .CW(CW), .STEP(STEP)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (src_addr_i),
    .cnt_i  (byte_cnt_i),
    .step_i (step),
    .addr_o (mem_addr_o),
    .busy_o (busy),
    .last_o (last)
  );

  flyby_dma_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .single_i (single_i),
    .dir_i    (dir_i),
    .busy_i   (busy),
    .last_i   (last),
    .go_i     (go),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o),
    .ack_o    (ack_o),
    .oe_o     (data_oe_o),
    .cap_o    (cap),
    .step_o   (step),
    .done_o   (done_o)
  );

  flyby_dma_hold #(.DW(DW)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .d_i    (rd_data_i),
    .q_o    (wr_data_o)
  );

  // R8
  ack_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (req_i && enable_i));

  // R9
  done_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mem_rd_o || mem_wr_o));

  // R7
  oe_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> mem_wr_o);
endmodule

// File: tb/test_flyby_dma_seq.sv
module test_flyby_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1, start = 1'b0, single = 1'b0, dir = 1'b0, req = 1'b0;
  logic [31:0] addr = '0;
  logic [15:0] cnt = '0;
  logic [31:0] rdata = '0;
  logic [31:0] maddr, wdata;
  logic        rd, wr, ack, oe, done;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  flyby_dma_seq i_flyby_dma_seq (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .start_i(start),
    .single_i(single), .dir_i(dir), .src_addr_i(addr), .byte_cnt_i(cnt),
    .req_i(req), .rd_data_i(rdata), .mem_addr_o(maddr), .mem_rd_o(rd),
    .mem_wr_o(wr), .ack_o(ack), .data_oe_o(oe), .wr_data_o(wdata), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobes(input string tag, input logic e_rd, e_wr, e_ack, e_oe, e_done);
    chk({tag, " rd"},   32'(rd),   32'(e_rd));
    chk({tag, " wr"},   32'(wr),   32'(e_wr));
    chk({tag, " ack"},  32'(ack),  32'(e_ack));
    chk({tag, " oe"},   32'(oe),   32'(e_oe));
    chk({tag, " done"}, 32'(done), 32'(e_done));
  endtask

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  task automatic load(input logic s, d, input logic [31:0] a, input logic [15:0] c);
    @(negedge clk);
    single = s; dir = d; addr = a; cnt = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    strobes("R1 in reset", 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    nxt();
    strobes("R1 after reset", 0, 0, 0, 0, 0);
  endtask

  task automatic t_fly_m2d();
    req = 1'b1;
    load(1, 1, 32'h100, 16'd8);
    nxt();
    strobes("R3 fly m2d unit0", 1, 0, 1, 0, 0);
    chk("R5 addr unit0", maddr, 32'h100);
    nxt();
    strobes("R9 fly m2d unit1", 1, 0, 1, 0, 1);
    chk("R5 addr unit1", maddr, 32'h104);
    nxt();
    strobes("R5 stopped", 0, 0, 0, 0, 0);
  endtask

  task automatic t_fly_d2m();
    req = 1'b1;
    load(1, 0, 32'h300, 16'd4);
    nxt();
    strobes("R4 fly d2m", 0, 1, 1, 0, 1);
    chk("R4 addr", maddr, 32'h300);
    nxt();
    strobes("R4 idle after", 0, 0, 0, 0, 0);
  endtask

  task automatic t_dual_m2d();
    req = 1'b1; rdata = 32'h1234_5678;
    load(0, 1, 32'h400, 16'd4);
    nxt();
    strobes("R6 read phase", 1, 0, 0, 0, 0);
    chk("R6 addr", maddr, 32'h400);
    @(negedge clk); rdata = 32'hdead_beef; #1;
    strobes("R6 write phase", 0, 1, 1, 1, 1);
    chk("R6 data", wdata, 32'h1234_5678);
    nxt();
    strobes("R6 idle after", 0, 0, 0, 0, 0);
  endtask

  task automatic t_dual_d2m();
    req = 1'b1; rdata = 32'hcafe_0007;
    load(0, 0, 32'h480, 16'd4);
    nxt();
    strobes("R7 device read", 1, 0, 1, 0, 0);
    @(negedge clk); rdata = 32'h0; #1;
    strobes("R7 memory write", 0, 1, 0, 1, 1);
    chk("R7 data", wdata, 32'hcafe_0007);
    chk("R7 addr", maddr, 32'h480);
  endtask

  task automatic t_pause_dual();
    req = 1'b1; rdata = 32'h11;
    load(0, 1, 32'h500, 16'd8);
    nxt();
    strobes("R8 read", 1, 0, 0, 0, 0);
    @(negedge clk); req = 1'b0; rdata = 32'h22; #1;
    strobes("R8 stalled write", 0, 0, 0, 0, 0);
    @(negedge clk); req = 1'b1; #1;
    strobes("R8 resumed write", 0, 1, 1, 1, 0);
    chk("R8 held data", wdata, 32'h11);
    chk("R8 addr", maddr, 32'h500);
    nxt();
    strobes("R8 second read", 1, 0, 0, 0, 0);
    chk("R5 dual addr step", maddr, 32'h504);
    nxt();
    strobes("R9 dual last write", 0, 1, 1, 1, 1);
    chk("R8 second data", wdata, 32'h22);
    nxt();
    strobes("R8 dual idle", 0, 0, 0, 0, 0);
  endtask

  task automatic t_gate_fly();
    req = 1'b0;
    load(1, 1, 32'h600, 16'd8);
    nxt();
    strobes("R8 waiting no req", 0, 0, 0, 0, 0);
    // start while pending must be dropped
    load(1, 0, 32'h700, 16'd4);
    @(negedge clk); req = 1'b1; en = 1'b0; #1;
    strobes("R8 disabled", 0, 0, 0, 0, 0);
    nxt();
    strobes("R8 disabled hold", 0, 0, 0, 0, 0);
    @(negedge clk); en = 1'b1; #1;
    nxt();
    strobes("R2 old mode kept", 1, 0, 1, 0, 0);
    chk("R2 old addr kept", maddr, 32'h600);
    @(negedge clk); req = 1'b0; #1;
    strobes("R8 req drop in fly", 0, 0, 0, 0, 0);
    @(negedge clk); req = 1'b1; #1;
    nxt();
    strobes("R8 fly resumed last", 1, 0, 1, 0, 1);
    chk("R5 addr after pause", maddr, 32'h604);
    nxt();
    strobes("R8 fly done idle", 0, 0, 0, 0, 0);
  endtask

  task automatic t_zero();
    req = 1'b1;
    load(1, 1, 32'h800, 16'd0);
    for (int i = 0; i < 3; i++) begin
      nxt();
      strobes("R2 zero count", 0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fly_m2d();
    t_fly_d2m();
    t_dual_m2d();
    t_dual_d2m();
    t_pause_dual();
    t_gate_fly();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule